// File: doc/BRIEF.md
# Two-Wire Serial Controller Register Bank

This block is the software-visible register file that sits beside the protocol engine of a two-wire serial bus controller. A processor reaches it over a simple single-cycle bus: a byte offset, a write enable and write data in, with read data returned combinationally in the same cycle. Writes take effect at the next rising clock edge.

The control byte has no direct write path. Software raises bits by writing ones to one offset and lowers bits by writing ones to another. Bit 3 of the control byte is the serial interrupt flag, and the protocol engine raises it with a one-cycle strobe. On that edge the engine's 5-bit state code is captured into the status register. The captured code then stays unchanged until software clears the flag. The block also holds the transfer data byte, the node's own address with its general-call enable, and two 16-bit values for the high and low halves of the generated clock period. It drives all of these back to the engine.

Top module: `twi_regbank`

## Requirements
- R1: After reset, control, data and own-address read 0x00, status reads 0xF8, and the clock high-time and low-time values are both 0x0004.
- R2: A write to offset 0x00 sets each control bit whose write-data bit is 1 and leaves the others unchanged. A read of offset 0x00 returns the control byte, and the control byte is always driven on `ctrl`.
- R3: A write to offset 0x18 clears each control bit whose write-data bit is 1 and leaves the others unchanged. A read of offset 0x18 returns zero.
- R4: Offset 0x04 is read-only. It returns the captured code in bits 7:3, with bits 2:0 and all upper bits reading zero. A write to it changes no register.
- R5: When `irq_set` raises the interrupt flag (control bit 3) while the flag is low, `state_code` is captured into status. While the flag stays high, status holds its value even if `state_code` changes or `irq_set` pulses again.
- R6: Only `irq_set` can raise control bit 3. A 1 written to bit 3 at offset 0x00 is ignored, and a 1 written to bit 3 at offset 0x18 clears it.
- R7: If `irq_set` and a software clear of bit 3 fall in the same cycle, the flag stays set and the current `state_code` is captured as a new event.
- R8: Offset 0x08 is a read/write data byte that is driven on `tx_byte`.
- R9: Offset 0x0C is read/write. Bits 7:1 are driven on `own_addr` and bit 0 is driven on `gcall_en`.
- R10: Offsets 0x10 and 0x14 hold 16-bit clock high-time and low-time values. They are read/write and are driven on `scl_high` and `scl_low`.
- R11: Any other offset, including the unaligned ones, reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| state_code | input | 5 | Current state code from the protocol engine |
| irq_set | input | 1 | One-cycle strobe that raises the interrupt flag |
| ctrl | output | 8 | Control byte; bit 3 is the interrupt flag |
| tx_byte | output | 8 | Data byte |
| own_addr | output | 7 | Own 7-bit address |
| gcall_en | output | 1 | General-call response enable |
| scl_high | output | 16 | Clock high-time count |
| scl_low | output | 16 | Clock low-time count |

## Verification
The set and clear paths are tried with all-ones, nibble and mixed masks. These runs tell an OR/AND-NOT update apart from a plain overwrite, and show that bit 3 cannot be raised by software. The interrupt strobe is driven with the flag low, with the flag high, and in the same cycle as a clear, while the incoming code changes between events. These three cases tell a first capture, a frozen status and the strobe-wins rule apart. A pseudo-random phase mixes writes to every mapped offset and to unmapped, unaligned and read-only ones with random strobes. On every clock it compares all outputs and the read data against a behavioural model, so that a write which leaks into the wrong register is caught.

// File: rtl/twi_regbank.sv
module twi_regbank #(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int CODE_W = 5,
  parameter int TIME_W = 16,
  parameter int FLAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CODE_W-1:0] state_code,
  input  logic              irq_set,
  output logic [7:0]        ctrl,
  output logic [7:0]        tx_byte,
  output logic [6:0]        own_addr,
  output logic              gcall_en,
  output logic [TIME_W-1:0] scl_high,
  output logic [TIME_W-1:0] scl_low
);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_DAT  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_ADR  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_HI   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_LO   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8'h18);
  localparam int PAD_W = 8 - CODE_W;
  localparam logic [TIME_W-1:0] TIME_RST = TIME_W'(4);

  logic [7:0]        ctrl_q;
  logic [CODE_W-1:0] code_q;
  logic [7:0]        dat_q;
  logic [7:0]        adr_q;
  logic [TIME_W-1:0] hi_q, lo_q;

  wire wr_set = bus_we && bus_addr == OFF_SET;
  wire wr_clr = bus_we && bus_addr == OFF_CLR;
  wire flag   = ctrl_q[FLAG_BIT];

  logic [7:0] set_mask, clr_mask;
  always_comb begin
    set_mask = wr_set ? bus_wdata[7:0] : 8'h00;
    set_mask[FLAG_BIT] = 1'b0;
    clr_mask = wr_clr ? bus_wdata[7:0] : 8'h00;
  end

  wire flag_clr = clr_mask[FLAG_BIT];
  wire capture  = irq_set && (!flag || flag_clr);

  logic [7:0] ctrl_d;
  always_comb begin
    ctrl_d = (ctrl_q | set_mask) & ~clr_mask;
    if (irq_set) ctrl_d[FLAG_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      code_q <= '1;
      dat_q  <= '0;
      adr_q  <= '0;
      hi_q   <= TIME_RST;
      lo_q   <= TIME_RST;
    end else begin
      ctrl_q <= ctrl_d;
      if (capture) code_q <= state_code;
      if (bus_we) begin
        case (bus_addr)
          OFF_DAT: dat_q <= bus_wdata[7:0];
          OFF_ADR: adr_q <= bus_wdata[7:0];
          OFF_HI:  hi_q  <= bus_wdata[TIME_W-1:0];
          OFF_LO:  lo_q  <= bus_wdata[TIME_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_SET:  bus_rdata[7:0] = ctrl_q;
      OFF_STAT: bus_rdata[7:0] = {code_q, {PAD_W{1'b0}}};
      OFF_DAT:  bus_rdata[7:0] = dat_q;
      OFF_ADR:  bus_rdata[7:0] = adr_q;
      OFF_HI:   bus_rdata[TIME_W-1:0] = hi_q;
      OFF_LO:   bus_rdata[TIME_W-1:0] = lo_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign tx_byte  = dat_q;
  assign own_addr = adr_q[7:1];
  assign gcall_en = adr_q[0];
  assign scl_high = hi_q;
  assign scl_low  = lo_q;

  // R5
  stat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> $stable(code_q));

  // R5
  flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> ctrl_q[FLAG_BIT]);

  // R6
  flag_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !irq_set |=> !ctrl_q[FLAG_BIT]);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && bus_wdata[FLAG_BIT] && !irq_set |=> !ctrl_q[FLAG_BIT]);

  // R4
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == OFF_STAT |=> $stable(dat_q) && $stable(adr_q) && $stable(hi_q) && $stable(lo_q));

  always_comb begin
    if (rst_n && bus_addr == OFF_CLR) begin
      // R3
      clr_read_zero_chk: assert (bus_rdata == '0);
    end
    if (rst_n && bus_addr == OFF_STAT) begin
      // R4
      stat_low_zero_chk: assert (bus_rdata[2:0] == 3'b000 && bus_rdata[BUS_W-1:8] == '0);
    end
  end
endmodule

// File: tb/twi_regbank_tb_top.sv
module twi_regbank_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [4:0]  state_code = 0;
  logic        irq_set = 0;
  logic [7:0]  ctrl, tx_byte;
  logic [6:0]  own_addr;
  logic        gcall_en;
  logic [15:0] scl_high, scl_low;

  always #2 clk = ~clk;

  twi_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .state_code(state_code),
    .irq_set(irq_set), .ctrl(ctrl), .tx_byte(tx_byte), .own_addr(own_addr),
    .gcall_en(gcall_en), .scl_high(scl_high), .scl_low(scl_low));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  int m_ctrl, m_code, m_dat, m_adr, m_hi, m_lo;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_code = 31; m_dat = 0; m_adr = 0; m_hi = 4; m_lo = 4;
    end else begin
      int was_flag, cleared;
      was_flag = (m_ctrl >> 3) & 1;
      cleared = 0;
      if (bus_we) begin
        if (bus_addr == 5'h00) m_ctrl = m_ctrl | (bus_wdata[7:0] & 8'hF7);
        else if (bus_addr == 5'h18) begin
          m_ctrl = m_ctrl & ~int'(bus_wdata[7:0]) & 8'hFF;
          cleared = bus_wdata[3];
        end
        else if (bus_addr == 5'h08) m_dat = bus_wdata[7:0];
        else if (bus_addr == 5'h0C) m_adr = bus_wdata[7:0];
        else if (bus_addr == 5'h10) m_hi = bus_wdata[15:0];
        else if (bus_addr == 5'h14) m_lo = bus_wdata[15:0];
      end
      if (irq_set) begin
        if (!was_flag || cleared) m_code = state_code;
        m_ctrl = m_ctrl | 8;
      end
    end
  end

  function automatic int exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return m_ctrl;
      5'h04: return m_code * 8;
      5'h08: return m_dat;
      5'h0C: return m_adr;
      5'h10: return m_hi;
      5'h14: return m_lo;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [4:0] a);
    case (a)
      5'h00: return "R2";
      5'h04: return "R4";
      5'h08: return "R8";
      5'h0C: return "R9";
      5'h10, 5'h14: return "R10";
      5'h18: return "R3";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 ctrl", ctrl, m_ctrl);
    chk(rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
    chk("R8 tx_byte", tx_byte, m_dat);
    chk("R9 own_addr", {own_addr, gcall_en}, m_adr);
    chk("R10 scl_high", scl_high, m_hi);
    chk("R10 scl_low", scl_low, m_lo);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    step();
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd_expect(input logic [4:0] a, input int exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_expect(5'h04, 32'hF8, "R1 status");
    rd_expect(5'h00, 0, "R1 ctrl");
    rd_expect(5'h08, 0, "R1 data");
    rd_expect(5'h0C, 0, "R1 adr");
    rd_expect(5'h10, 4, "R1 scl_high");
    rd_expect(5'h14, 4, "R1 scl_low");
    // R2 / R6: set all, bit 3 ignored
    wr(5'h00, 32'hFF);
    rd_expect(5'h00, 32'hF7, "R6 sw set of flag ignored");
    // R3 clear low nibble, read of clear offset is zero
    wr(5'h18, 32'h0F);
    rd_expect(5'h00, 32'hF0, "R3 clear mask");
    rd_expect(5'h18, 0, "R3 clear offset reads zero");
    wr(5'h00, 32'h05);
    rd_expect(5'h00, 32'hF5, "R2 set mask OR");
    // R5 capture
    state_code = 5'h0A; irq_set = 1; step(); irq_set = 0;
    chk("R5 flag raised", ctrl[3], 1);
    rd_expect(5'h04, 32'h50, "R5 capture");
    state_code = 5'h11; step();
    irq_set = 1; step(); irq_set = 0;
    rd_expect(5'h04, 32'h50, "R5 frozen while flag high");
    // R4 write to status ignored
    wr(5'h04, 32'hFFFF_FFFF);
    rd_expect(5'h04, 32'h50, "R4 status read-only");
    // R7 simultaneous
    state_code = 5'h03; irq_set = 1; wr(5'h18, 32'h08); irq_set = 0;
    chk("R7 flag kept", ctrl[3], 1);
    rd_expect(5'h04, 32'h18, "R7 new capture");
    wr(5'h18, 32'h08);
    chk("R6 flag cleared", ctrl[3], 0);
    state_code = 5'h1E; step();
    rd_expect(5'h04, 32'h18, "R5 held after clear");
    // R8..R10
    wr(5'h08, 32'h1234_56A5);
    chk("R8 tx_byte", tx_byte, 8'hA5);
    wr(5'h0C, 32'h6B);
    chk("R9 own_addr", own_addr, 7'h35);
    chk("R9 gcall_en", gcall_en, 1);
    wr(5'h10, 32'hAB12_1234);
    wr(5'h14, 32'h0000_BEEF);
    chk("R10 scl_high", scl_high, 16'h1234);
    chk("R10 scl_low", scl_low, 16'hBEEF);
    // R11 unmapped
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    wr(5'h11, 32'h0000_0000);
    rd_expect(5'h1C, 0, "R11 unmapped read");
    rd_expect(5'h02, 0, "R11 unaligned read");
    chk("R11 data unchanged", tx_byte, 8'hA5);
    chk("R11 scl_high unchanged", scl_high, 16'h1234);
    chk("R11 ctrl unchanged", ctrl, 8'hF5);
    // random mix
    begin
      logic [31:0] lfsr = 32'hACE1_2345;
      for (int i = 0; i < 600; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        bus_addr = (lfsr[2:0] == 3'd7) ? lfsr[8:4] : {lfsr[5:3] % 3'd7, 2'b00};
        bus_we = lfsr[9];
        bus_wdata = {lfsr[15:0], lfsr[31:16]};
        irq_set = (lfsr[12:10] == 3'd0);
        state_code = lfsr[20:16];
        step();
      end
      bus_we = 0; irq_set = 0;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule